// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is an I2C slave in front of a small byte-wide memory array. A master selects it with a fixed 7-bit device address. The lowest bit of the address byte chooses the direction: 0 means write and 1 means read. The block supports four operations:

- **Byte write:** an address byte, then a word address byte, then one data byte.
- **Random read:** a write-mode address byte and a word address, then a repeated START and a read-mode address byte.
- **Current-address read:** a read-mode address byte alone, which reads from the internal address counter.
- **Sequential read:** a read in which the master acknowledges each byte, so the block keeps sending the following bytes.

SCL and SDA are open-drain lines. Each is sampled through a synchroniser clocked by a fast system clock. The block drives SDA only through a pull-low enable.

The data byte of a write is held pending and is stored in the array only when the STOP arrives. That STOP also starts a busy timer, which stands in for a non-volatile programming cycle. While the timer runs, the block answers no address byte, so a master can poll the block until it acknowledges again. An internal counter always points one past the last byte that was written or read.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_oe_o` = 0) and is not busy, so the first matching address byte is acknowledged.
- R2: A write-mode address byte equal to `{DEV_ADDR, 0}`, a word address byte and a data byte are each acknowledged by pulling SDA low during the ninth clock. After the STOP, the data byte reads back from that word address.
- R3: The pending data byte is stored only on a STOP. A repeated START after the data byte discards the pending byte, and so does a START or STOP in the middle of a byte. In both cases the array is unchanged and no busy cycle starts.
- R4: For `BUSY_CYCLES` system clocks after the STOP that commits a write, the block acknowledges no address byte, with R/W either 0 or 1. After the timer expires, address bytes are acknowledged again.
- R5: An address byte whose upper 7 bits differ from `DEV_ADDR` is not acknowledged. The block keeps SDA released until the next START, so data clocked afterwards reads as 0xFF.
- R6: A random read returns the byte at the word address loaded by the dummy write.
- R7: After a write or a read of address n, a current-address read returns the byte at n+1, modulo the array depth.
- R8: If the master acknowledges a read byte (SDA low on the ninth clock), the block sends the byte at the next address. The address wraps from DEPTH-1 to 0.
- R9: A master NACK on the ninth clock of a read ends the transfer, and the block releases SDA until the next START. A STOP given during the ninth clock also ends the read. In both cases the counter has already advanced past the byte that was sent.
- R10: Read data is sent MSB first, and the block changes its SDA drive only while SCL is low.
- R11: Only the low `ADDR_W` bits of the word address byte select the location. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples SCL and SDA |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line (wired-AND bus value) |
| sda_oe_o | output | 1 | Pull SDA low when 1, release the line when 0 |

## Verification
Each change of the block's SDA drive follows an SCL falling edge at the pin by three system clocks: two synchroniser stages and one state register. The master model therefore waits ten clocks of SCL low before it raises SCL, and it samples SDA five clocks into the high phase, long after the drive has settled. A committed byte becomes visible to a read at the STOP. The busy window is checked twice. Poll bytes are sent so that their eighth bit completes well inside the window, and the bench waits `BUSY_CYCLES` plus a margin before it expects acknowledges again.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT_STOP
  } slv_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  // idle bus is high, so reset the chain to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/i2c_mem_busy.sv
module i2c_mem_busy #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (start_i)     cnt <= CNT_W'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign busy_o = (cnt != '0);

  assert_busy_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  assert_busy_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned BUSY_CYCLES = 1_250_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit;

  slv_state_e state;
  logic [3:0] bit_cnt;
  byte_t      rx_sh, tx_sh, pend_data, rd_data;
  addr_t      addr_cnt, pend_addr;
  logic       rw_q, mack_q, pend_valid, sda_oe_q;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) i_bus_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  assign commit = stop_det & pend_valid;

  i2c_mem_busy #(.CYCLES(BUSY_CYCLES)) i_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (busy)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_array (
    .clk_i  (clk_i),
    .we_i   (commit),
    .waddr_i(pend_addr),
    .wdata_i(pend_data),
    .raddr_i(addr_cnt),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      addr_cnt   <= '0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_valid <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
    end else if (start_det) begin
      state      <= ST_DEV;
      bit_cnt    <= '0;
      sda_oe_q   <= 1'b0;
      pend_valid <= 1'b0;
    end else if (stop_det) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      sda_oe_q   <= 1'b0;
      pend_valid <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            case (state)
              ST_DEV: begin
                if (rx_sh[7:1] == DEV_ADDR && !busy) begin
                  rw_q     <= rx_sh[0];
                  sda_oe_q <= 1'b1;
                  state    <= ST_DEV_ACK;
                end else begin
                  state    <= ST_IDLE;
                end
              end
              ST_WADDR: begin
                addr_cnt <= rx_sh[ADDR_W-1:0];
                sda_oe_q <= 1'b1;
                state    <= ST_WADDR_ACK;
              end
              default: begin
                pend_valid <= 1'b1;
                pend_addr  <= addr_cnt;
                pend_data  <= rx_sh;
                addr_cnt   <= addr_cnt + addr_t'(1);
                sda_oe_q   <= 1'b1;
                state      <= ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_sh    <= rd_data;
              sda_oe_q <= ~rd_data[BYTE_W-1];
              state    <= ST_RDATA;
            end else begin
              sda_oe_q <= 1'b0;
              state    <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state    <= ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state    <= ST_WAIT_STOP;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              bit_cnt  <= '0;
              sda_oe_q <= 1'b0;
              addr_cnt <= addr_cnt + addr_t'(1);
              state    <= ST_RACK;
            end else begin
              tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~tx_sh[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_sh    <= rd_data;
              sda_oe_q <= ~rd_data[BYTE_W-1];
              state    <= ST_RDATA;
            end else begin
              state    <= ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  assert_sda_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> !scl_s);

  assert_drive_states_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_q |-> (state inside {ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

  assert_no_ack_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DEV_ACK) |-> !busy);

  assert_pending_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid |-> (state inside {ST_WDATA_ACK, ST_WAIT_STOP}));

  assert_read_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RACK && $past(state) == ST_RDATA) |->
      (addr_cnt == addr_t'($past(addr_cnt) + addr_t'(1))));

endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;

  localparam int          ADDR_W = 4;
  localparam int          DEPTH  = 1 << ADDR_W;
  localparam int          BUSY   = 1000;
  localparam int          HP     = 10;
  localparam logic [6:0]  DEV    = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_mem_slave #(
    .DEV_ADDR   (DEV),
    .ADDR_W     (ADDR_W),
    .BUSY_CYCLES(BUSY)
  ) i_i2c_mem_slave (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int viol = 0;
  logic [7:0] ref_mem [DEPTH];
  int ref_cnt = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int a);
    return ref_mem[a % DEPTH];
  endfunction

  // R10 monitor: drive must not move while SCL is high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(posedge clk) begin
    #1;
    if (rst_n && m_scl && prev_scl && sda_oe != prev_oe) viol++;
    prev_oe  = sda_oe;
    prev_scl = m_scl;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; cyc(HP);
    m_scl = 1'b1; cyc(HP);
    m_sda = 1'b0; cyc(HP);
    m_scl = 1'b0; cyc(HP);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; cyc(HP);
    m_scl = 1'b1; cyc(HP);
    m_sda = 1'b1; cyc(HP);
  endtask

  task automatic send_bit(bit b);
    m_sda = b;    cyc(HP);
    m_scl = 1'b1; cyc(HP);
    m_scl = 1'b0; cyc(2);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; cyc(HP);
    m_scl = 1'b1; cyc(HP / 2);
    b = sda_line; cyc(HP / 2);
    m_scl = 1'b0; cyc(2);
  endtask

  task automatic send_byte(logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_bits8(output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit mack);
    recv_bits8(d);
    send_bit(~mack);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    bit k;
    bus_start;
    send_byte({DEV, 1'b0}, k); chk("R2 dev ack", k, 1);
    send_byte(a, k);           chk("R2 waddr ack", k, 1);
    send_byte(d, k);           chk("R2 data ack", k, 1);
    bus_stop;
    ref_mem[a % DEPTH] = d;
    ref_cnt = (a + 1) % DEPTH;
  endtask

  task automatic wait_busy;
    cyc(BUSY + 50);
  endtask

  task automatic do_rand_read(logic [7:0] a, int n);
    bit k;
    logic [7:0] d;
    bus_start;
    send_byte({DEV, 1'b0}, k); chk("R6 dummy dev ack", k, 1);
    send_byte(a, k);           chk("R6 waddr ack", k, 1);
    bus_start;
    send_byte({DEV, 1'b1}, k); chk("R6 read dev ack", k, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      if (i == 0) chk("R6 R11 random read", d, exp_byte(a + i));
      else        chk("R8 sequential read", d, exp_byte(a + i));
    end
    bus_stop;
    ref_cnt = (a + n) % DEPTH;
  endtask

  task automatic do_cur_read(int n);
    bit k;
    logic [7:0] d;
    bus_start;
    send_byte({DEV, 1'b1}, k); chk("R7 cur dev ack", k, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      chk("R7 current read", d, exp_byte(ref_cnt + i));
    end
    bus_stop;
    ref_cnt = (ref_cnt + n) % DEPTH;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit k;
    logic [7:0] d;
    logic [7:0] old;
    void'($urandom(32'h1c0ffee));
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 reset release", sda_oe, 0);

    // fill array; the first write also shows R1 (not busy after reset)
    for (int a = 0; a < DEPTH; a++) begin
      do_write(a[7:0], 8'($urandom));
      wait_busy;
    end

    // R4 acknowledge polling
    do_write(8'd3, 8'hA5);
    bus_start;
    send_byte({DEV, 1'b1}, k); chk("R4 busy read nack", k, 0);
    bus_stop;
    bus_start;
    send_byte({DEV, 1'b0}, k); chk("R4 busy write nack", k, 0);
    bus_stop;
    wait_busy;
    do_cur_read(1);  // R4 acked again, R7 after write at 3
    do_rand_read(8'd3, 1);

    // R5 address mismatch
    bus_start;
    send_byte({DEV ^ 7'h01, 1'b1}, k); chk("R5 mismatch nack", k, 0);
    recv_bits8(d);                     chk("R5 released", d, 8'hFF);
    bus_stop;
    bus_start;
    send_byte({7'h23, 1'b0}, k);       chk("R5 mismatch write nack", k, 0);
    send_byte(8'h07, k);               chk("R5 no ack later", k, 0);
    bus_stop;

    // R11 upper word address bits ignored
    do_rand_read(8'hF2, 1);
    // R8 sequential read wrapping
    do_rand_read(8'd14, 4);

    // R9 NACK ends read and the block stays silent
    do_cur_read(1);
    bus_start;
    send_byte({DEV, 1'b1}, k); chk("R9 dev ack", k, 1);
    recv_byte(d, 1'b0);        chk("R9 data", d, exp_byte(ref_cnt));
    ref_cnt = (ref_cnt + 1) % DEPTH;
    recv_bits8(d);             chk("R9 released after nack", d, 8'hFF);
    bus_stop;
    // STOP during ninth clock
    bus_start;
    send_byte({DEV, 1'b1}, k); chk("R9 dev ack stop", k, 1);
    recv_bits8(d);             chk("R9 data stop", d, exp_byte(ref_cnt));
    ref_cnt = (ref_cnt + 1) % DEPTH;
    bus_stop;
    do_cur_read(1);

    // R3 abort by repeated START after data byte
    old = ref_mem[5];
    bus_start;
    send_byte({DEV, 1'b0}, k); chk("R3 dev ack", k, 1);
    send_byte(8'd5, k);        chk("R3 waddr ack", k, 1);
    send_byte(~old, k);        chk("R3 data ack", k, 1);
    bus_start;
    bus_stop;
    do_rand_read(8'd5, 1);     // no busy, old data
    chk("R3 unchanged 5", ref_mem[5], old);
    // R3 abort by STOP mid-byte
    bus_start;
    send_byte({DEV, 1'b0}, k); chk("R3 dev ack mid", k, 1);
    send_byte(8'd6, k);        chk("R3 waddr ack mid", k, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop;
    do_rand_read(8'd6, 1);

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 4)
        0: begin
          do_write(8'($urandom), 8'($urandom));
          wait_busy;
        end
        1: do_rand_read(8'($urandom % DEPTH), 1 + int'($urandom % 3));
        2: do_cur_read(1 + int'($urandom % 3));
        default: do_rand_read(8'($urandom), 1 + int'($urandom % 4));
      endcase
    end

    chk("R10 drive only while SCL low", viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule